// File: doc/BRIEF.md
# Read-Only Converter Result I2C Target

This block lets an I2C bus controller read the most recent result of an analog-to-digital converter. It watches the bus lines with the system clock and recognises START, repeated START and STOP. It checks a 7-bit address, which a strap input picks from two fixed values, and accepts read requests only. After it acknowledges its address, it returns a frozen copy of the last result, high byte first and MSB first. It drives SDA only by pulling it low through an output-enable, with an external pull-up assumed.

Results come in as a plain valid strobe with no back-pressure. Every cycle with `res_valid` high overwrites the held result, and the block never stalls the converter. While `conv_busy` is high, the block refuses its own address, so a controller can poll it to learn whether a conversion has finished. The system clock must run at least 8 times the SCL rate. SCL and SDA each pass through a two-flop synchronizer before edge detection.

Top module: `adc_i2c_rd_slave`

## Requirements
- R1: A falling SDA while SCL is high is a START. It restarts address reception from bit zero in any state, including in the middle of an address or data byte (repeated START).
- R2: A rising SDA while SCL is high is a STOP. It returns the block to idle with SDA released, and further SCL clocking without a new START draws no response.
- R3: The block's address is 0010100 when `addr_pick` is 0 and 1010100 when it is 1. The first byte after START is the address MSB first, followed by a read bit of 1. On a match the block pulls SDA low for the whole ninth clock.
- R4: If the address differs, or the bit after it is 0 (write), SDA stays released for the ninth clock and for the rest of the transfer.
- R5: If `conv_busy` is high when the eighth address bit is sampled, the block does not acknowledge, even for a matching read.
- R6: After the address ACK, the block sends the 16-bit result as its high byte, then its low byte, each MSB first. When the controller acknowledges the last byte, sending restarts with the high byte.
- R7: The result is captured when the address is accepted. Strobes of `res_valid` during the read do not change the bytes of that read.
- R8: The block asserts its SDA pull-down only while SCL is low.
- R9: A NAK from the controller after a data byte makes the block release SDA until the next START or STOP.
- R10: `res_valid` high for one cycle stores `res_data`. The next accepted read returns the most recently stored value.
- R11: After reset, SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line as seen on the bus |
| sda_in | input | 1 | SDA line as seen on the bus |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_pick | input | 1 | Strap that selects one of the two addresses |
| res_data | input | 16 | Completed conversion result |
| res_valid | input | 1 | Strobe that stores `res_data` |
| conv_busy | input | 1 | High while a conversion is in progress |

## Verification
The bench sweeps every possible first byte under both strap settings, so every address and direction combination is covered. A wrong address constant, a swapped strap polarity or a missing read-bit check would show up as a spurious ACK or a missing one. It starts a new result in the middle of a read and expects the old low byte: a block that read the live value instead of a snapshot would tear the word. It issues a repeated START halfway through an address, where a bit counter that is not cleared would shift the address. It also sends a controller NAK followed by extra clocking, where a block that kept driving would corrupt the bus. A monitor counts every change of the pull-down made while SCL is high.

// File: rtl/adc_i2c_pkg.sv
package adc_i2c_pkg;
  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ADDR,
    LK_ADDR_ACK,
    LK_TX,
    LK_TX_ACK,
    LK_PARK
  } link_state_t;

  localparam logic [6:0] ADDR_STRAP_LO = 7'b0010100;
  localparam logic [6:0] ADDR_STRAP_HI = 7'b1010100;
endpackage

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int DEPTH = STAGES + 1;

  logic [1:0] line_in;
  logic [DEPTH-1:0] chain [2];

  assign line_in = {sda_in, scl_in};

  // One synchronizer chain per bus line; the last stage is the previous sample.
  for (genvar g = 0; g < 2; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= '1;
      else        chain[g] <= {chain[g][DEPTH-2:0], line_in[g]};
    end
  end

  logic scl_prev, sda_prev;
  assign scl_s    = chain[0][STAGES-1];
  assign scl_prev = chain[0][STAGES];
  assign sda_s    = chain[1][STAGES-1];
  assign sda_prev = chain[1][STAGES];

  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/adc_result_hold.sv
module adc_result_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         res_valid,
  input  logic [W-1:0] res_data,
  output logic [W-1:0] held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         held <= '0;
    else if (res_valid) held <= res_data;
  end

  assert_store_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> held == $past(res_data));
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(held));
endmodule

// File: rtl/adc_i2c_rd_slave.sv
module adc_i2c_rd_slave
  import adc_i2c_pkg::*;
#(
  parameter int         RES_W  = 16,
  parameter int         STAGES = 2,
  parameter logic [6:0] ADDR_A = ADDR_STRAP_LO,
  parameter logic [6:0] ADDR_B = ADDR_STRAP_HI
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_pull,
  input  logic             addr_pick,
  input  logic [RES_W-1:0] res_data,
  input  logic             res_valid,
  input  logic             conv_busy
);
  localparam int NBYTES = RES_W / 8;
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBYTES - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [RES_W-1:0] held, snap;

  i2c_bus_monitor #(.STAGES(STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  adc_result_hold #(.W(RES_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .held(held)
  );

  link_state_t      st;
  logic [2:0]       bit_cnt;
  logic [6:0]       addr_sr;
  logic [7:0]       tx_byte;
  logic [IDX_W-1:0] idx;
  logic [7:0]       next_byte;
  logic [6:0]       own_addr;
  logic [7:0]       first_byte;

  assign own_addr   = addr_pick ? ADDR_B : ADDR_A;
  assign first_byte = {addr_sr, sda_s};

  always_comb begin
    next_byte = '0;
    for (int k = 0; k < NBYTES; k++)
      if (idx == IDX_W'(k)) next_byte = snap[(NBYTES-1-k)*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= LK_IDLE;
      bit_cnt  <= '0;
      addr_sr  <= '0;
      tx_byte  <= '0;
      idx      <= '0;
      snap     <= '0;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      st       <= LK_IDLE;
      sda_pull <= 1'b0;
    end else if (start_det) begin
      st       <= LK_ADDR;
      bit_cnt  <= '0;
      sda_pull <= 1'b0;
    end else begin
      case (st)
        LK_ADDR: if (scl_rise) begin
          addr_sr <= first_byte[6:0];
          if (bit_cnt == 3'd7) begin
            bit_cnt <= '0;
            idx     <= '0;
            if (first_byte == {own_addr, 1'b1} && !conv_busy) begin
              st   <= LK_ADDR_ACK;
              snap <= held;
            end else begin
              st <= LK_PARK;
            end
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
          end
        end
        LK_ADDR_ACK: if (scl_fall) begin
          if (!sda_pull) begin
            sda_pull <= 1'b1;
          end else begin
            st       <= LK_TX;
            tx_byte  <= next_byte;
            sda_pull <= ~next_byte[7];
            idx      <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
          end
        end
        LK_TX: if (scl_fall) begin
          if (bit_cnt == 3'd7) begin
            st       <= LK_TX_ACK;
            bit_cnt  <= '0;
            sda_pull <= 1'b0;
          end else begin
            tx_byte  <= {tx_byte[6:0], 1'b0};
            sda_pull <= ~tx_byte[6];
            bit_cnt  <= bit_cnt + 3'd1;
          end
        end
        LK_TX_ACK: begin
          if (scl_rise && sda_s) begin
            st <= LK_PARK;
          end else if (scl_fall) begin
            st       <= LK_TX;
            tx_byte  <= next_byte;
            sda_pull <= ~next_byte[7];
            idx      <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assert_pull_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);
  assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (st == LK_IDLE && !sda_pull));
  assert_start_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (st == LK_ADDR && bit_cnt == 3'd0));
  assert_busy_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LK_ADDR && scl_rise && bit_cnt == 3'd7 && conv_busy && !start_det && !stop_det)
      |=> st == LK_PARK);
  assert_drive_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> (st == LK_ADDR_ACK || st == LK_TX));
  assert_nak_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == LK_TX_ACK && scl_rise && sda_s && !start_det && !stop_det)
      |=> (st == LK_PARK && !sda_pull));
endmodule

// File: tb/adc_i2c_rd_slave_test.sv
module adc_i2c_rd_slave_test;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        addr_pick = 1'b0;
  logic [15:0] res_data = '0;
  logic        res_valid = 1'b0;
  logic        conv_busy = 1'b0;
  logic        sda_pull;
  logic        sda_line;

  int checks = 0;
  int errors = 0;
  int r8_viol = 0;
  logic prev_pull = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  adc_i2c_rd_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .addr_pick(addr_pick), .res_data(res_data),
    .res_valid(res_valid), .conv_busy(conv_busy)
  );

  // R8 monitor: the pull-down must not change while SCL is high
  always @(negedge clk) begin
    if (rst_n && sda_pull !== prev_pull && scl_m) r8_viol++;
    prev_pull = sda_pull;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    tick(2); sda_m = 1'b1; tick(H-2); scl_m = 1'b1; tick(H);
    sda_m = 1'b0; tick(H); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    tick(2); sda_m = 1'b0; tick(H-2); scl_m = 1'b1; tick(H);
    sda_m = 1'b1; tick(H);
  endtask

  task automatic put_bit(input logic b);
    tick(2); sda_m = b; tick(H-2); scl_m = 1'b1; tick(H); scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic v);
    tick(2); sda_m = 1'b1; tick(H-2); scl_m = 1'b1; tick(H/2);
    v = sda_line; tick(H - H/2); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(a);
    acked = ~a;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] v);
    logic bv;
    for (int i = 7; i >= 0; i--) begin
      get_bit(bv);
      v[i] = bv;
    end
    put_bit(~m_ack);
  endtask

  task automatic load_result(input logic [15:0] v);
    res_data = v; res_valid = 1'b1; tick(1); res_valid = 1'b0;
  endtask

  function automatic logic [6:0] own(input logic sel);
    return sel ? 7'b1010100 : 7'b0010100;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ak;
    logic [7:0] hi, lo, b3;
    logic [15:0] val;

    tick(3);
    chk("R11 released in reset", {31'd0, sda_pull}, 32'd0);
    rst_n = 1'b1;
    tick(4);
    chk("R11 released after reset", {31'd0, sda_line}, 32'd1);

    // Sweep all first bytes under both strap settings
    for (int s = 0; s < 2; s++) begin
      addr_pick = s[0];
      val = s[0] ? 16'h3C96 : 16'hE1B4;
      load_result(val);
      for (int b = 0; b < 256; b++) begin
        logic exp_ack;
        exp_ack = (b[7:1] == own(s[0])) && b[0];
        bus_start();
        send_byte(b[7:0], ak);
        if (exp_ack) begin
          chk("R3 address ack", {31'd0, ak}, 32'd1);
          recv_byte(1'b1, hi);
          recv_byte(1'b0, lo);
          chk("R6 high byte", {24'd0, hi}, {24'd0, val[15:8]});
          chk("R6 low byte", {24'd0, lo}, {24'd0, val[7:0]});
        end else begin
          chk("R4 no ack", {31'd0, ak}, 32'd0);
        end
        bus_stop();
      end
    end

    addr_pick = 1'b0;
    load_result(16'h1357);

    // R5: busy converter refuses its own read address
    conv_busy = 1'b1;
    bus_start();
    send_byte({own(1'b0), 1'b1}, ak);
    chk("R5 busy nak", {31'd0, ak}, 32'd0);
    bus_stop();
    conv_busy = 1'b0;

    // R1: repeated START in the middle of an address
    bus_start();
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start();
    send_byte({own(1'b0), 1'b1}, ak);
    chk("R1 ack after restart", {31'd0, ak}, 32'd1);
    recv_byte(1'b1, hi);
    chk("R1 data after restart", {24'd0, hi}, 32'h13);
    // R9: controller NAK, then stray clocks see a released line
    recv_byte(1'b0, lo);
    chk("R9 last byte", {24'd0, lo}, 32'h57);
    recv_byte(1'b0, b3);
    chk("R9 released after nak", {24'd0, b3}, 32'hFF);
    // R1: repeated START while busy, without STOP
    bus_start();
    send_byte({own(1'b0), 1'b1}, ak);
    chk("R1 ack on repeated start", {31'd0, ak}, 32'd1);
    recv_byte(1'b0, hi);
    chk("R1 data on repeated start", {24'd0, hi}, 32'h13);
    bus_stop();

    // R7: new result mid-read does not tear; R10: next read sees it
    bus_start();
    send_byte({own(1'b0), 1'b1}, ak);
    recv_byte(1'b1, hi);
    load_result(16'hBEEF);
    recv_byte(1'b0, lo);
    chk("R7 snapshot low byte", {24'd0, lo}, 32'h57);
    bus_stop();
    bus_start();
    send_byte({own(1'b0), 1'b1}, ak);
    recv_byte(1'b1, hi);
    recv_byte(1'b1, lo);
    recv_byte(1'b0, b3);
    chk("R10 new result high", {24'd0, hi}, 32'hBE);
    chk("R10 new result low", {24'd0, lo}, 32'hEF);
    chk("R6 wrap to high byte", {24'd0, b3}, 32'hBE);
    bus_stop();

    // R2: clocking after STOP without START draws nothing
    recv_byte(1'b0, b3);
    chk("R2 idle after stop", {24'd0, b3}, 32'hFF);
    chk("R2 pull released", {31'd0, sda_pull}, 32'd0);

    chk("R8 pull changes with SCL high", r8_viol, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule